// File: doc/BRIEF.md
# Bit-Banged Bias DAC Serial Writer

This block sends one complete two-wire write frame to a bias-voltage DAC by issuing a sequence of whole-register writes to a single power-control register. In every value it writes, one bit acts as the serial clock line and a second bit acts as the serial data line. All other bits are copied from a base value that the caller supplies, so the other power-control bits stay as the caller set them while the frame is sent.

The link is write-only. Each acknowledge slot is sent as a blind clock pulse with the data line low, and nothing is read back. A frame consists of the following, in order:

- a start condition;
- the fixed device byte 0x9C, then an acknowledge slot;
- the fixed control byte 0x00, then an acknowledge slot;
- the caller's value byte, then an acknowledge slot;
- a stop condition.

Consecutive register writes are separated by a settle interval. Its length in cycles is the clock frequency in MHz multiplied by the settle time in microseconds. The caller pulses `start_i` with the base and value present. The block then emits strobes on `wr_o` with `wr_data_o`, and it pulses `done_o` after the last write has settled.

Top module: `dac_bitbang_writer`

## Requirements
- R1: While reset is held and after it is released with no start, `wr_o` and `done_o` stay low.
- R2: A start sampled high while idle captures `base_i` and `value_i`, and the first write strobe appears in the very next cycle.
- R3: Successive strobes within a frame are exactly SETTLE_CYCLES = CLK_FREQ_MHZ*SETTLE_US cycles apart. `wr_o` is high for one cycle per write.
- R4: In every written word, all bits other than the clock bit (bit 0) and the data bit (bit 1) equal the base value captured at start.
- R5: The start condition is three writes with {clock, data} equal to {1,1}, then {1,0}, then {0,0}.
- R6: Each serial bit is three writes: clock low, clock high, clock low, with the data bit held constant across all three.
- R7: Bytes go out most significant bit first, and the three bytes are 0x9C, 0x00 and the captured value, in that order.
- R8: After each byte, one acknowledge slot is sent as an ordinary bit with data low.
- R9: The stop condition is three writes with {clock, data} equal to {0,0}, then {1,0}, then {1,1}.
- R10: A frame contains exactly 87 writes.
- R11: `done_o` is high for exactly one cycle, SETTLE_CYCLES cycles after the last stop write.
- R12: A start request arriving while a frame is in progress, including the done cycle, is ignored. The frame in flight keeps its captured base and value, and no extra frame follows.
- R13: A start held high continuously launches a new frame on the first idle cycle after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request, sampled while idle |
| base_i | input | REG_W | Base register value for the non-line bits |
| value_i | input | 8 | Data byte sent as the third byte |
| wr_o | output | 1 | Register write strobe |
| wr_data_o | output | REG_W | Register value for the current write |
| done_o | output | 1 | One-cycle frame completion pulse |

## Verification
The frame is driven with four kinds of input, and each one separates a different class of fault:

- A zero base with a mixed value byte exposes bit-order and byte-order faults.
- A base with its high bits set shows whether the non-line bits pass through unchanged.
- A base with both line bits set, paired with a zero value byte, proves that the line bits are always overridden and that acknowledge slots carry data low.
- Start pulses with different base and value during a frame, followed by a start held high across two frames, separate correct request gating from early acceptance or lost re-triggering.

A behavioural model predicts every cycle's strobe, word and done flag, so any error in timing or in a single word is caught.

// File: rtl/dac_bb_pkg.sv
package dac_bb_pkg;

    typedef enum logic [1:0] {
        SEG_START = 2'd0,
        SEG_BYTE  = 2'd1,
        SEG_STOP  = 2'd2
    } seg_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } fsm_e;

    localparam int PHASES      = 3;
    localparam int FRAME_BYTES = 3;

    function automatic int frame_writes(input int byte_w, input int n_bytes);
        return PHASES + n_bytes * (byte_w + 1) * PHASES + PHASES;
    endfunction

endpackage

// File: rtl/dac_bb_settle_timer.sv
module dac_bb_settle_timer #(
    parameter int SETTLE_CYCLES = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CNT_W'(SETTLE_CYCLES - 2);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0) && !load_i;

    // R3: a load always restarts the countdown from its top value
    assert_timer_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_q == CNT_W'(SETTLE_CYCLES - 2)));

endmodule

// File: rtl/dac_bb_frame_seq.sv
module dac_bb_frame_seq
    import dac_bb_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    localparam int BIT_W    = $clog2(BYTE_W + 1),
    localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             adv_i,
    output seg_e             seg_o,
    output logic [IDX_W-1:0] byte_idx_o,
    output logic [BIT_W-1:0] bit_idx_o,
    output logic [1:0]       phase_o,
    output logic             last_o
);
    localparam logic [BIT_W-1:0] ACK_SLOT  = BIT_W'(BYTE_W);
    localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(NUM_BYTES - 1);
    localparam logic [1:0]       LAST_PH   = 2'(PHASES - 1);

    typedef struct packed {
        seg_e             seg;
        logic [IDX_W-1:0] byte_idx;
        logic [BIT_W-1:0] bit_idx;
        logic [1:0]       phase;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (clear_i) begin
            seq_d = '{seg: SEG_START, byte_idx: '0, bit_idx: '0, phase: '0};
        end else if (adv_i) begin
            if (seq_q.phase == LAST_PH) begin
                seq_d.phase = '0;
                unique case (seq_q.seg)
                    SEG_START: begin
                        seq_d.seg      = SEG_BYTE;
                        seq_d.byte_idx = '0;
                        seq_d.bit_idx  = '0;
                    end
                    SEG_BYTE: begin
                        if (seq_q.bit_idx == ACK_SLOT) begin
                            seq_d.bit_idx = '0;
                            if (seq_q.byte_idx == LAST_BYTE) seq_d.seg = SEG_STOP;
                            else seq_d.byte_idx = seq_q.byte_idx + 1'b1;
                        end else begin
                            seq_d.bit_idx = seq_q.bit_idx + 1'b1;
                        end
                    end
                    default: seq_d.seg = SEG_STOP;
                endcase
            end else begin
                seq_d.phase = seq_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '{seg: SEG_START, byte_idx: '0, bit_idx: '0, phase: '0};
        else         seq_q <= seq_d;
    end

    assign seg_o      = seq_q.seg;
    assign byte_idx_o = seq_q.byte_idx;
    assign bit_idx_o  = seq_q.bit_idx;
    assign phase_o    = seq_q.phase;
    assign last_o     = (seq_q.seg == SEG_STOP) && (seq_q.phase == LAST_PH);

    // R6: each bit spans exactly three phases
    assert_phase_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.phase <= LAST_PH);

    // R8: the slot after the last data bit is the acknowledge, never beyond
    assert_bit_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.bit_idx <= ACK_SLOT);

endmodule

// File: rtl/dac_bb_line_encoder.sv
module dac_bb_line_encoder
    import dac_bb_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int CLK_BIT = 0,
    parameter int DAT_BIT = 1,
    parameter int BYTE_W  = 8,
    localparam int BIT_W  = $clog2(BYTE_W + 1)
) (
    input  logic [REG_W-1:0]  base_i,
    input  logic [BYTE_W-1:0] cur_byte_i,
    input  seg_e              seg_i,
    input  logic [BIT_W-1:0]  bit_idx_i,
    input  logic [1:0]        phase_i,
    output logic [REG_W-1:0]  word_o
);
    logic             scl, sda;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        shifted = cur_byte_i << bit_idx_i;
        scl     = 1'b0;
        sda     = 1'b0;
        unique case (seg_i)
            SEG_START: begin
                scl = (phase_i != 2'd2);
                sda = (phase_i == 2'd0);
            end
            SEG_STOP: begin
                scl = (phase_i != 2'd0);
                sda = (phase_i == 2'd2);
            end
            default: begin
                scl = (phase_i == 2'd1);
                sda = (bit_idx_i < BIT_W'(BYTE_W)) ? shifted[BYTE_W-1] : 1'b0;
            end
        endcase
        word_o          = base_i;
        word_o[CLK_BIT] = scl;
        word_o[DAT_BIT] = sda;
    end

endmodule

// File: rtl/dac_bitbang_writer.sv
module dac_bitbang_writer
    import dac_bb_pkg::*;
#(
    parameter int         REG_W        = 8,
    parameter int         CLK_BIT      = 0,
    parameter int         DAT_BIT      = 1,
    parameter int         CLK_FREQ_MHZ = 100,
    parameter int         SETTLE_US    = 10,
    parameter logic [7:0] DEV_BYTE     = 8'h9C,
    parameter logic [7:0] CTRL_BYTE    = 8'h00
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [REG_W-1:0] base_i,
    input  logic [7:0]       value_i,
    output logic             wr_o,
    output logic [REG_W-1:0] wr_data_o,
    output logic             done_o
);
    localparam int BYTE_W        = 8;
    localparam int SETTLE_CYCLES = CLK_FREQ_MHZ * SETTLE_US;
    localparam int BIT_W         = $clog2(BYTE_W + 1);
    localparam int IDX_W         = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
    localparam int N_WRITES      = frame_writes(BYTE_W, FRAME_BYTES);
    localparam logic [REG_W-1:0] LINE_MASK =
        (REG_W'(1) << CLK_BIT) | (REG_W'(1) << DAT_BIT);

    typedef struct packed {
        fsm_e              fsm;
        logic [REG_W-1:0]  base;
        logic [BYTE_W-1:0] value;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tmr_load, tmr_expired;
    logic             seq_clear, seq_adv, seq_last;
    seg_e             seg;
    logic [IDX_W-1:0] byte_idx;
    logic [BIT_W-1:0] bit_idx;
    logic [1:0]       phase;
    logic [BYTE_W-1:0] cur_byte;

    always_comb begin
        ctl_d     = ctl_q;
        tmr_load  = 1'b0;
        seq_clear = 1'b0;
        seq_adv   = 1'b0;
        unique case (ctl_q.fsm)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.fsm   = ST_WRITE;
                    ctl_d.base  = base_i;
                    ctl_d.value = value_i;
                    seq_clear   = 1'b1;
                end
            end
            ST_WRITE: begin
                tmr_load  = 1'b1;
                ctl_d.fsm = ST_WAIT;
            end
            ST_WAIT: begin
                if (tmr_expired) begin
                    if (seq_last) begin
                        ctl_d.fsm = ST_DONE;
                    end else begin
                        seq_adv   = 1'b1;
                        ctl_d.fsm = ST_WRITE;
                    end
                end
            end
            default: ctl_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '{fsm: ST_IDLE, base: '0, value: '0};
        else         ctl_q <= ctl_d;
    end

    always_comb begin
        unique case (byte_idx)
            IDX_W'(0): cur_byte = DEV_BYTE;
            IDX_W'(1): cur_byte = CTRL_BYTE;
            default:   cur_byte = ctl_q.value;
        endcase
    end

    dac_bb_settle_timer #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (tmr_load),
        .expired_o(tmr_expired)
    );

    dac_bb_frame_seq #(
        .BYTE_W   (BYTE_W),
        .NUM_BYTES(FRAME_BYTES)
    ) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (seq_clear),
        .adv_i     (seq_adv),
        .seg_o     (seg),
        .byte_idx_o(byte_idx),
        .bit_idx_o (bit_idx),
        .phase_o   (phase),
        .last_o    (seq_last)
    );

    dac_bb_line_encoder #(
        .REG_W  (REG_W),
        .CLK_BIT(CLK_BIT),
        .DAT_BIT(DAT_BIT),
        .BYTE_W (BYTE_W)
    ) u_enc (
        .base_i    (ctl_q.base),
        .cur_byte_i(cur_byte),
        .seg_i     (seg),
        .bit_idx_i (bit_idx),
        .phase_i   (phase),
        .word_o    (wr_data_o)
    );

    assign wr_o   = (ctl_q.fsm == ST_WRITE);
    assign done_o = (ctl_q.fsm == ST_DONE);

    // Checker state: cycles since the last strobe and strobes in this frame
    logic [31:0] gap_q, wcnt_q;
    logic        seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q  <= '0;
            wcnt_q <= '0;
            seen_q <= 1'b0;
        end else begin
            if (wr_o) gap_q <= 32'd1;
            else if (gap_q != 32'hFFFF_FFFF) gap_q <= gap_q + 1;
            if (ctl_q.fsm == ST_IDLE) begin
                seen_q <= 1'b0;
                wcnt_q <= '0;
            end else if (wr_o) begin
                seen_q <= 1'b1;
                wcnt_q <= wcnt_q + 1;
            end
        end
    end

    // R3: strobe spacing inside a frame
    assert_strobe_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_o && seen_q) |-> (gap_q == 32'(SETTLE_CYCLES)));

    // R10: write count per frame
    assert_frame_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (wcnt_q == 32'(N_WRITES)));

    // R11: done is a single-cycle pulse, one settle after the last write
    assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    assert_done_spacing_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (gap_q == 32'(SETTLE_CYCLES)));

    // R4: non-line bits follow the captured base
    assert_base_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_o |-> ((wr_data_o & ~LINE_MASK) == (ctl_q.base & ~LINE_MASK)));

    // R12: captured operands hold while busy
    assert_busy_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.fsm != ST_IDLE) |=> ($stable(ctl_q.base) && $stable(ctl_q.value)));

endmodule

// File: tb/dac_bitbang_writer_tb.sv
module dac_bitbang_writer_tb;
    localparam int REG_W = 8;
    localparam int MHZ   = 4;
    localparam int US    = 1;
    localparam int S     = MHZ * US;
    localparam int NW    = 87;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [REG_W-1:0] base = '0;
    logic [7:0]       value = '0;
    logic             wr, done;
    logic [REG_W-1:0] wr_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dac_bitbang_writer #(
        .REG_W(REG_W), .CLK_BIT(0), .DAT_BIT(1),
        .CLK_FREQ_MHZ(MHZ), .SETTLE_US(US)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .base_i(base), .value_i(value),
        .wr_o(wr), .wr_data_o(wr_data), .done_o(done)
    );

    // Behavioural reference model
    logic [7:0] exp_q[$];
    string      tag_q[$];
    int         m_state = 0;   // 0 idle, 1 busy, 2 done
    int         m_gap   = 0;
    logic       e_wr = 1'b0, e_done = 1'b0;
    logic [7:0] e_data = '0;
    string      e_tag = "";
    int         frames_exp = 0, frames_seen = 0, strobes_seen = 0;

    function automatic logic [7:0] word(input logic [7:0] b, input bit c, input bit d);
        return {b[7:2], d, c};
    endfunction

    task automatic push(input logic [7:0] b, input bit c, input bit d, input string t);
        exp_q.push_back(word(b, c, d));
        tag_q.push_back(t);
    endtask

    task automatic build(input logic [7:0] b, input logic [7:0] v);
        logic [7:0] bytes [3];
        bytes[0] = 8'h9C; bytes[1] = 8'h00; bytes[2] = v;
        push(b, 1, 1, "R2 R5"); push(b, 1, 0, "R5"); push(b, 0, 0, "R5");
        for (int k = 0; k < 3; k++) begin
            for (int i = 7; i >= 0; i--) begin
                push(b, 0, bytes[k][i], "R7"); push(b, 1, bytes[k][i], "R6");
                push(b, 0, bytes[k][i], "R7");
            end
            push(b, 0, 0, "R8"); push(b, 1, 0, "R8"); push(b, 0, 0, "R8");
        end
        push(b, 0, 0, "R9"); push(b, 1, 0, "R9"); push(b, 1, 1, "R9");
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; e_wr = 0; e_done = 0; exp_q.delete(); tag_q.delete();
        end else begin
            e_wr = 0; e_done = 0;
            if (m_state == 2) begin
                m_state = 0;
            end else if (m_state == 0) begin
                if (start) begin
                    build(base, value);
                    m_state = 1;
                    frames_exp++;
                    e_wr = 1; e_data = exp_q.pop_front(); e_tag = tag_q.pop_front();
                    m_gap = S;
                end
            end else begin
                m_gap--;
                if (m_gap == 0) begin
                    if (exp_q.size() != 0) begin
                        e_wr = 1; e_data = exp_q.pop_front(); e_tag = tag_q.pop_front();
                        m_gap = S;
                    end else begin
                        e_done = 1; m_state = 2;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (wr !== e_wr) begin
                n_bad++;
                $display("FAIL R3 strobe: actual %b expected %b at %0t", wr, e_wr, $time);
            end
            n_cmp++;
            if (done !== e_done) begin
                n_bad++;
                $display("FAIL R11 done: actual %b expected %b at %0t", done, e_done, $time);
            end
            if (e_wr && wr) begin
                strobes_seen++;
                n_cmp++;
                if (wr_data[1:0] !== e_data[1:0]) begin
                    n_bad++;
                    $display("FAIL %s line bits: actual %b expected %b at %0t",
                             e_tag, wr_data[1:0], e_data[1:0], $time);
                end
                n_cmp++;
                if (wr_data[7:2] !== e_data[7:2]) begin
                    n_bad++;
                    $display("FAIL R4 base bits: actual %h expected %h", wr_data, e_data);
                end
            end
            if (done) begin
                frames_seen++;
                n_cmp++;
                if (strobes_seen != NW) begin
                    n_bad++;
                    $display("FAIL R10 writes per frame: actual %0d expected %0d",
                             strobes_seen, NW);
                end
                strobes_seen = 0;
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (m_state != 0);
    endtask

    task automatic frame(input logic [7:0] b, input logic [7:0] v);
        @(negedge clk);
        start = 1; base = b; value = v;
        @(negedge clk);
        start = 0; base = ~b; value = ~v;
        wait_idle();
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_cmp++;
        if (wr !== 1'b0 || done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset outputs: actual %b%b expected 00", wr, done);
        end
        rst_n = 1;
        repeat (5) @(negedge clk);
        n_cmp++;
        if (wr !== 1'b0 || done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 idle outputs: actual %b%b expected 00", wr, done);
        end

        frame(8'h00, 8'h7D);   // R7 bit order
        frame(8'hE4, 8'hFF);   // R4 base pass-through
        // R12: base with line bits set, value zero, start spam mid-frame
        @(negedge clk);
        start = 1; base = 8'hFF; value = 8'h00;
        @(negedge clk);
        start = 0;
        for (int k = 0; k < 20; k++) begin
            repeat (7) @(negedge clk);
            start = 1; base = 8'h5A + 8'(k); value = 8'hC3;
            @(negedge clk);
            start = 0;
        end
        wait_idle();
        repeat (3) @(negedge clk);
        n_cmp++;
        if (frames_seen != 3) begin
            n_bad++;
            $display("FAIL R12 frame count: actual %0d expected 3", frames_seen);
        end

        // R13: start held high across two frames
        @(negedge clk);
        start = 1; base = 8'h30; value = 8'hA5;
        wait_idle();
        @(negedge clk);
        wait_idle();
        start = 0;
        repeat (2 * S + 4) @(negedge clk);
        wait_idle();
        n_cmp++;
        if (frames_seen != frames_exp || frames_seen < 5) begin
            n_bad++;
            $display("FAIL R13 frames: actual %0d expected %0d", frames_seen, frames_exp);
        end
        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule